// File: doc/BRIEF.md
# Adaptive Stale Prefetch Dropper

This block watches the slots of a shared memory request buffer. It removes prefetch requests that have waited in the buffer longer than their issuing core can justify. Each slot holds a valid flag, a prefetch flag, the number of the issuing core, the cache-line address and an age count. The age count advances once per clock while the slot is occupied.

Every core reports its measured prefetch accuracy as a percentage. A banded lookup turns that figure into an age limit for the core, so a core with poor accuracy has its prefetches discarded sooner than one with good accuracy. A demand request for a line that a waiting prefetch already covers turns that prefetch into a demand, and the slot is then safe from dropping. A dropped slot is freed, and a one-cycle pulse on that slot's index tells the surrounding controller to release any resources tied to it.

Slot allocation and retirement are decided outside this block and are presented to it as index-addressed commands. Accuracy measurement also happens elsewhere.

Top module: `sd_stale_dropper`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every slot reads invalid, no prefetch flag is set and no drop pulse is raised.
- R2: An allocate command loads the addressed slot on the next clock edge with valid set, the given prefetch flag, core number and line, and an age of zero. It replaces whatever the slot held before.
- R3: An occupied slot's age rises by one on every clock edge and saturates at 2^AGE_W-1 instead of wrapping to zero.
- R4: An occupied prefetch slot whose age is strictly greater than its core's limit is freed on the next edge. On that same edge its drop pulse rises, and the pulse lasts exactly one cycle. A slot whose age equals the limit is kept.
- R5: A core's limit comes from its accuracy A (0 to 100) with lower-inclusive bands: A below EDGE_LO gives THR_0, A from EDGE_LO to below EDGE_MID gives THR_1, A from EDGE_MID to below EDGE_HI gives THR_2, and A at or above EDGE_HI gives THR_3. The defaults are edges 10, 30 and 70 and limits of 100, 1500, 50000 and 100000 cycles.
- R6: Each slot is judged against the limit of the core number stored in that slot, using that core's accuracy in the current cycle.
- R7: A demand whose line equals the line of an occupied slot clears that slot's prefetch flag on the next edge, and the slot stays valid. A demand wins over a drop that falls due on the same edge.
- R8: A slot whose prefetch flag is clear is never dropped, however long it waits.
- R9: A retire command frees the addressed slot on the next edge with no drop pulse. An allocate command to the same slot in the same cycle takes priority over the retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld | input | 1 | Load a slot this cycle |
| alloc_idx | input | IDX_W | Slot to load |
| alloc_pref | input | 1 | Loaded request is a prefetch |
| alloc_core | input | CORE_W | Issuing core of the loaded request |
| alloc_line | input | LINE_W | Cache-line address of the loaded request |
| retire_vld | input | 1 | Free a slot this cycle (request served) |
| retire_idx | input | IDX_W | Slot to free |
| dem_vld | input | 1 | A demand request is presented this cycle |
| dem_line | input | LINE_W | Line address of the demand |
| core_acc | input | NUM_CORES*ACC_W | Accuracy percentage per core, core 0 in the low bits |
| ent_valid | output | NUM_ENTRIES | Slot occupied flags |
| ent_pref | output | NUM_ENTRIES | Slot prefetch flags |
| drop_pulse | output | NUM_ENTRIES | One-cycle pulse per slot dropped as stale |

## Verification
The dropping behaviour is first driven one accuracy value at a time, stepping across both sides of every band edge. For each value the delay from allocation to drop pulse must equal the band's limit plus two cycles, which separates an off-by-one band boundary from an off-by-one age comparison. Separate patterns check that several cores with different accuracies age side by side, that a demand arrives on the exact edge a drop falls due, that demand-only slots wait indefinitely, and that retire and allocate collide on one slot. In one scenario a prefetch slot sits past the counter's maximum and its core's accuracy then drops: a saturating age triggers an immediate drop, while a wrapped age would not. A long random mix of all commands then compares every flag and pulse against a behavioural model on each cycle.

// File: rtl/sd_pkg.sv
package sd_pkg;

  // Per-slot action chosen each cycle, in priority order
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_FREE = 2'd2,
    ACT_AGE  = 2'd3
  } slot_act_e;

endpackage

// File: rtl/sd_band_lookup.sv
module sd_band_lookup #(
  parameter int ACC_W    = 7,
  parameter int AGE_W    = 17,
  parameter int EDGE_LO  = 10,
  parameter int EDGE_MID = 30,
  parameter int EDGE_HI  = 70,
  parameter int THR_0    = 100,
  parameter int THR_1    = 1500,
  parameter int THR_2    = 50000,
  parameter int THR_3    = 100000
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [AGE_W-1:0] thr_o
);

  localparam logic [ACC_W-1:0] EDGE_LO_V  = ACC_W'(EDGE_LO);
  localparam logic [ACC_W-1:0] EDGE_MID_V = ACC_W'(EDGE_MID);
  localparam logic [ACC_W-1:0] EDGE_HI_V  = ACC_W'(EDGE_HI);

  // Lower-inclusive bands: an edge value belongs to the band above it
  always_comb begin
    if (acc_i < EDGE_LO_V) begin
      thr_o = AGE_W'(THR_0);
    end else if (acc_i < EDGE_MID_V) begin
      thr_o = AGE_W'(THR_1);
    end else if (acc_i < EDGE_HI_V) begin
      thr_o = AGE_W'(THR_2);
    end else begin
      thr_o = AGE_W'(THR_3);
    end
  end

endmodule

// File: rtl/sd_entry.sv
module sd_entry
  import sd_pkg::*;
#(
  parameter int CORE_W = 2,
  parameter int LINE_W = 8,
  parameter int AGE_W  = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              free_i,
  input  logic              load_pref_i,
  input  logic [CORE_W-1:0] load_core_i,
  input  logic [LINE_W-1:0] load_line_i,
  input  logic              dem_vld_i,
  input  logic [LINE_W-1:0] dem_line_i,
  input  logic [AGE_W-1:0]  thr_i,
  output logic              valid_o,
  output logic              pref_o,
  output logic [CORE_W-1:0] core_o,
  output logic              drop_o
);

  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
  localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

  slot_act_e         act;
  logic              valid_q, valid_d;
  logic              pref_q, pref_d;
  logic              drop_q, drop_d;
  logic [CORE_W-1:0] core_q;
  logic [LINE_W-1:0] line_q;
  logic [AGE_W-1:0]  age_q, age_d;
  logic              age_en;
  logic              dem_hit;
  logic              stale;

  assign dem_hit = dem_vld_i && valid_q && (line_q == dem_line_i);
  assign stale   = pref_q && (age_q > thr_i);

  // Next-state
  always_comb begin
    if (load_i) begin
      act = ACT_LOAD;
    end else if (free_i) begin
      act = ACT_FREE;
    end else if (valid_q) begin
      act = ACT_AGE;
    end else begin
      act = ACT_IDLE;
    end

    valid_d = valid_q;
    pref_d  = pref_q;
    age_d   = age_q;
    drop_d  = 1'b0;

    unique case (act)
      ACT_LOAD: begin
        valid_d = 1'b1;
        pref_d  = load_pref_i;
        age_d   = '0;
      end
      ACT_FREE: begin
        valid_d = 1'b0;
        pref_d  = 1'b0;
      end
      ACT_AGE: begin
        age_d = (age_q == AGE_MAX) ? age_q : (age_q + AGE_ONE);
        if (dem_hit) begin
          pref_d = 1'b0;
        end else if (stale) begin
          valid_d = 1'b0;
          pref_d  = 1'b0;
          drop_d  = 1'b1;
        end
      end
      default: begin
      end
    endcase
  end

  assign age_en = (act == ACT_LOAD) || (act == ACT_AGE);

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pref_q  <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      pref_q  <= pref_d;
      drop_q  <= drop_d;
    end
  end

  // Data registers, no reset
  always_ff @(posedge clk) begin
    if (load_i) begin
      core_q <= load_core_i;
      line_q <= load_line_i;
    end
  end

  always_ff @(posedge clk) begin
    if (age_en) begin
      age_q <= age_d;
    end
  end

  assign valid_o = valid_q;
  assign pref_o  = pref_q;
  assign core_o  = core_q;
  assign drop_o  = drop_q;

  AST_DROP_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |-> !valid_q) else $error("drop left slot valid"); // R4

  AST_DROP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |=> !drop_q) else $error("drop pulse longer than one cycle"); // R4

  AST_DROP_NEEDS_PREF: assert property (@(posedge clk) disable iff (!rst_n)
    drop_q |-> $past(pref_q && valid_q)) else $error("dropped a non-prefetch slot"); // R8

  AST_AGE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(valid_q) && $past(age_q == AGE_MAX) && !$past(load_i) && !$past(free_i))
      |-> (age_q == AGE_MAX)) else $error("age wrapped"); // R3

  AST_DEMAND_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (dem_hit && !load_i && !free_i) |=> (valid_q && !pref_q && !drop_q)) else $error("promoted slot lost"); // R7

  AST_RETIRE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (free_i && !load_i) |=> (!valid_q && !drop_q)) else $error("retire misbehaved"); // R9

endmodule

// File: rtl/sd_stale_dropper.sv
module sd_stale_dropper #(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_CORES   = 4,
  parameter int LINE_W      = 8,
  parameter int ACC_W       = 7,
  parameter int AGE_W       = 17,
  parameter int EDGE_LO     = 10,
  parameter int EDGE_MID    = 30,
  parameter int EDGE_HI     = 70,
  parameter int THR_0       = 100,
  parameter int THR_1       = 1500,
  parameter int THR_2       = 50000,
  parameter int THR_3       = 100000,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int CORE_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_vld,
  input  logic [IDX_W-1:0]           alloc_idx,
  input  logic                       alloc_pref,
  input  logic [CORE_W-1:0]          alloc_core,
  input  logic [LINE_W-1:0]          alloc_line,
  input  logic                       retire_vld,
  input  logic [IDX_W-1:0]           retire_idx,
  input  logic                       dem_vld,
  input  logic [LINE_W-1:0]          dem_line,
  input  logic [NUM_CORES*ACC_W-1:0] core_acc,
  output logic [NUM_ENTRIES-1:0]     ent_valid,
  output logic [NUM_ENTRIES-1:0]     ent_pref,
  output logic [NUM_ENTRIES-1:0]     drop_pulse
);

  logic [AGE_W-1:0]  core_thr [NUM_CORES];
  logic [CORE_W-1:0] ent_core [NUM_ENTRIES];
  logic [AGE_W-1:0]  ent_thr  [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] load_vec;
  logic [NUM_ENTRIES-1:0] free_vec;

  // One limit per core, shared by all slots of that core
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    sd_band_lookup #(
      .ACC_W(ACC_W), .AGE_W(AGE_W),
      .EDGE_LO(EDGE_LO), .EDGE_MID(EDGE_MID), .EDGE_HI(EDGE_HI),
      .THR_0(THR_0), .THR_1(THR_1), .THR_2(THR_2), .THR_3(THR_3)
    ) u_lookup (
      .acc_i (core_acc[c*ACC_W +: ACC_W]),
      .thr_o (core_thr[c])
    );
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    assign load_vec[i] = alloc_vld  && (alloc_idx  == IDX_W'(i));
    assign free_vec[i] = retire_vld && (retire_idx == IDX_W'(i));
    assign ent_thr[i]  = core_thr[ent_core[i]];

    sd_entry #(
      .CORE_W(CORE_W), .LINE_W(LINE_W), .AGE_W(AGE_W)
    ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load_vec[i]),
      .free_i      (free_vec[i]),
      .load_pref_i (alloc_pref),
      .load_core_i (alloc_core),
      .load_line_i (alloc_line),
      .dem_vld_i   (dem_vld),
      .dem_line_i  (dem_line),
      .thr_i       (ent_thr[i]),
      .valid_o     (ent_valid[i]),
      .pref_o      (ent_pref[i]),
      .core_o      (ent_core[i]),
      .drop_o      (drop_pulse[i])
    );
  end

  AST_LOAD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_vld |=> ent_valid[$past(alloc_idx)]) else $error("allocated slot not valid"); // R2

  AST_PULSE_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ((drop_pulse & ~$past(ent_valid)) == '0)) else $error("pulse on empty slot"); // R4

endmodule

// File: tb/tb_sd_stale_dropper.sv
`timescale 1ns/1ps
module tb_sd_stale_dropper;

  localparam int N      = 8;
  localparam int NC     = 4;
  localparam int LW     = 8;
  localparam int AW     = 7;
  localparam int GW     = 6;
  localparam int E_LO   = 10;
  localparam int E_MID  = 30;
  localparam int E_HI   = 70;
  localparam int T0     = 3;
  localparam int T1     = 8;
  localparam int T2     = 20;
  localparam int T3     = 63;
  localparam int IW     = 3;
  localparam int CW     = 2;
  localparam int AGEMAX = (1 << GW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          alloc_vld = 1'b0;
  logic [IW-1:0] alloc_idx = '0;
  logic          alloc_pref = 1'b0;
  logic [CW-1:0] alloc_core = '0;
  logic [LW-1:0] alloc_line = '0;
  logic          retire_vld = 1'b0;
  logic [IW-1:0] retire_idx = '0;
  logic          dem_vld = 1'b0;
  logic [LW-1:0] dem_line = '0;
  logic [AW-1:0] acc [NC];
  logic [NC*AW-1:0] core_acc;
  logic [N-1:0]  ent_valid, ent_pref, drop_pulse;

  always_comb begin
    for (int c = 0; c < NC; c++) core_acc[c*AW +: AW] = acc[c];
  end

  sd_stale_dropper #(
    .NUM_ENTRIES(N), .NUM_CORES(NC), .LINE_W(LW), .ACC_W(AW), .AGE_W(GW),
    .EDGE_LO(E_LO), .EDGE_MID(E_MID), .EDGE_HI(E_HI),
    .THR_0(T0), .THR_1(T1), .THR_2(T2), .THR_3(T3)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_vld(alloc_vld), .alloc_idx(alloc_idx), .alloc_pref(alloc_pref),
    .alloc_core(alloc_core), .alloc_line(alloc_line),
    .retire_vld(retire_vld), .retire_idx(retire_idx),
    .dem_vld(dem_vld), .dem_line(dem_line), .core_acc(core_acc),
    .ent_valid(ent_valid), .ent_pref(ent_pref), .drop_pulse(drop_pulse)
  );

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit cmp_on = 1'b0;

  // Requirement-level band table
  function automatic int limit_of(int a);
    if (a < E_LO) return T0;
    if (a < E_MID) return T1;
    if (a < E_HI) return T2;
    return T3;
  endfunction

  // Behavioural reference model
  bit m_valid [N];
  bit m_pref  [N];
  bit m_drop  [N];
  int m_core  [N];
  int m_line  [N];
  int m_age   [N];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_valid[i] = 0; m_pref[i] = 0; m_drop[i] = 0;
        m_core[i] = 0; m_line[i] = 0; m_age[i] = 0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        int lim;
        bit hit;
        lim = limit_of(int'(acc[m_core[i]]));
        hit = dem_vld && m_valid[i] && (m_line[i] == int'(dem_line));
        m_drop[i] = 0;
        if (alloc_vld && int'(alloc_idx) == i) begin
          m_valid[i] = 1; m_pref[i] = alloc_pref; m_core[i] = int'(alloc_core);
          m_line[i] = int'(alloc_line); m_age[i] = 0;
        end else if (retire_vld && int'(retire_idx) == i) begin
          m_valid[i] = 0; m_pref[i] = 0;
        end else if (m_valid[i]) begin
          if (hit) m_pref[i] = 0;
          else if (m_pref[i] && m_age[i] > lim) begin
            m_valid[i] = 0; m_pref[i] = 0; m_drop[i] = 1;
          end
          if (m_age[i] < AGEMAX) m_age[i] = m_age[i] + 1;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      logic [N-1:0] ev, ep, ed;
      for (int i = 0; i < N; i++) begin
        ev[i] = m_valid[i]; ep[i] = m_pref[i]; ed[i] = m_drop[i];
      end
      check(phase, "ent_valid", int'(ent_valid), int'(ev));
      check(phase, "ent_pref", int'(ent_pref), int'(ep));
      check(phase, "drop_pulse", int'(drop_pulse), int'(ed));
    end
  end

  task automatic do_alloc(input int idx, input bit pf, input int core, input int line);
    alloc_vld = 1; alloc_idx = IW'(idx); alloc_pref = pf;
    alloc_core = CW'(core); alloc_line = LW'(line);
    @(negedge clk);
    alloc_vld = 0;
  endtask

  task automatic do_retire(input int idx);
    retire_vld = 1; retire_idx = IW'(idx);
    @(negedge clk);
    retire_vld = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int vals [8];
    for (int c = 0; c < NC; c++) acc[c] = AW'(100);
    idle(3);
    // R1: reset state
    check("R1", "valid in reset", int'(ent_valid), 0);
    check("R1", "pulse in reset", int'(drop_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid after reset", int'(ent_valid), 0);
    check("R1", "pref after reset", int'(ent_pref), 0);
    cmp_on = 1'b1;

    // R5 and R4: drop delay across every band edge
    vals = '{0, 9, 10, 29, 30, 69, 70, 100};
    foreach (vals[k]) begin
      int seen;
      phase = "R5";
      acc[0] = AW'(vals[k]);
      do_alloc(0, 1, 0, 1);
      seen = -1;
      for (int n = 1; n <= 80; n++) begin
        @(negedge clk);
        if (drop_pulse[0] && seen < 0) seen = n;
      end
      if (limit_of(vals[k]) >= AGEMAX) check("R5", "no drop at top band", seen, -1);
      else check("R4", "alloc-to-drop delay", seen, limit_of(vals[k]) + 2);
      if (ent_valid[0]) do_retire(0);
    end

    // R6: cores with different limits age side by side
    phase = "R6";
    acc[0] = AW'(5); acc[1] = AW'(20); acc[2] = AW'(50); acc[3] = AW'(90);
    for (int c = 0; c < NC; c++) do_alloc(c, 1, c, 10 + c);
    idle(30);
    for (int c = 0; c < NC; c++) if (ent_valid[c]) do_retire(c);

    // R7: demand promotes prefetches holding the same line
    phase = "R7";
    acc[0] = AW'(0);
    do_alloc(1, 1, 0, 5);
    do_alloc(2, 1, 0, 5);
    dem_vld = 1; dem_line = LW'(5);
    @(negedge clk);
    dem_vld = 0;
    idle(70);
    check("R7", "promoted slots kept", int'(ent_valid[2:1]), 3);
    // R7: demand on the very edge a drop is due
    do_alloc(3, 1, 0, 7);
    idle(T0 + 1);
    dem_vld = 1; dem_line = LW'(7);
    @(negedge clk);
    dem_vld = 0;
    check("R7", "demand beats due drop", int'(drop_pulse[3]), 0);
    idle(10);
    for (int i = 1; i <= 3; i++) do_retire(i);

    // R8: demand-only slot never dropped
    phase = "R8";
    do_alloc(4, 0, 0, 9);
    idle(80);
    check("R8", "demand slot survives", int'(ent_valid[4]), 1);
    do_retire(4);

    // R9 and R2: retire, re-allocate, collision
    phase = "R9";
    do_alloc(5, 1, 1, 3);
    do_retire(5);
    check("R9", "retire frees slot", int'(ent_valid[5]), 0);
    acc[1] = AW'(0);
    do_alloc(5, 1, 1, 3);
    idle(T0);
    phase = "R2";
    do_alloc(5, 1, 1, 3);
    idle(T0);
    check("R2", "re-alloc restarts age", int'(ent_valid[5]), 1);
    phase = "R9";
    alloc_vld = 1; alloc_idx = 3'd6; alloc_pref = 0; alloc_core = 0; alloc_line = 8'd2;
    retire_vld = 1; retire_idx = 3'd6;
    @(negedge clk);
    alloc_vld = 0; retire_vld = 0;
    check("R9", "alloc beats retire", int'(ent_valid[6]), 1);
    idle(10);
    do_retire(6);

    // R3: saturated age triggers an immediate drop once the limit falls
    phase = "R3";
    acc[2] = AW'(80);
    do_alloc(7, 1, 2, 44);
    idle(AGEMAX + 2);
    acc[2] = AW'(0);
    @(negedge clk);
    check("R3", "saturated age drops at once", int'(drop_pulse[7]), 1);

    // R4: random mix against the model
    phase = "R4";
    for (int t = 0; t < 4000; t++) begin
      if ($urandom_range(0, 19) == 0)
        acc[$urandom_range(0, NC - 1)] = AW'($urandom_range(0, 100));
      alloc_vld  = ($urandom_range(0, 9) < 2);
      alloc_idx  = IW'($urandom_range(0, N - 1));
      alloc_pref = ($urandom_range(0, 9) < 7);
      alloc_core = CW'($urandom_range(0, NC - 1));
      alloc_line = LW'($urandom_range(0, 7));
      retire_vld = ($urandom_range(0, 19) == 0);
      retire_idx = IW'($urandom_range(0, N - 1));
      dem_vld    = ($urandom_range(0, 9) < 1);
      dem_line   = LW'($urandom_range(0, 7));
      @(negedge clk);
    end
    alloc_vld = 0; retire_vld = 0; dem_vld = 0;
    idle(2);
    cmp_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule